// File: doc/BRIEF.md
# Masked Half-Precision Add-ReLU-to-Int8 Vector Unit

This unit turns two vectors of half-precision floating-point lanes into one vector of signed 8-bit lanes. In every lane enabled by its mask bit, it adds the two operands exactly, clamps a non-positive result to zero, and rounds once to the nearest integer, with ties going to even. It then saturates the result into the int8 range. Lanes whose mask bit is clear produce zero. Both sources always share one lane count, and the mask carries one bit per lane.

Whole vectors move through a three-stage pipeline. The input side uses a valid/ready handshake and so does the output side. While the consumer keeps ready high, one vector enters per cycle. When the consumer holds ready low, the pipeline freezes and nothing is lost. The unit has no effect beyond producing its output vector.

Top module: `addrelu_conv_vec`

## Requirements
- R1: For an active lane, the output is the integer nearest to max(0, a+b), saturated to 127. Example: 100+10 gives 110, and 128+(-1) gives 127.
- R2: Rounding happens once, on the exact sum. Subnormal operands count at their exact value. Example: 0.5 plus the smallest subnormal (0x3800 + 0x0001) gives 1.
- R3: A fraction of exactly one half rounds to the even integer. 0.5 gives 0, 1.5 gives 2, 2.5 gives 2 and 3.5 gives 4.
- R4: Any sum whose rounded value exceeds 127 gives 127, including 127.5 and 65504+65504. An output lane never has bit 7 set.
- R5: A negative sum, an exact zero and a negative zero all give 0.
- R6: A NaN operand gives 0, and so does the sum +inf + -inf. Otherwise an operand of +inf gives 127 and an operand of -inf gives 0. Half-precision encodings use exponent field bits [14:10] and mantissa bits [9:0], and exponent 31 marks inf or NaN.
- R7: Lane i is active only when mask_i[i] is 1; otherwise its output byte is 0 whatever the operands. Lane i reads a_i and b_i at bits [16i+15:16i] and writes data_o at bits [8i+7:8i].
- R8: A vector is accepted on a rising edge where valid_i and ready_o are both high. If the pipeline does not stall, valid_o rises with the matching data after the third rising edge, counting the accepting edge as the first.
- R9: While valid_o is high and ready_i is low, ready_o is low, and on the next cycle valid_o stays high with data_o unchanged. Vectors already in flight come out in order once ready_i returns.
- R10: During reset and after it, until the first result, valid_o is 0, data_o is 0 and ready_o is 1.
- R11: With ready_i held high, back-to-back input vectors come out on consecutive cycles in input order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input vector present |
| ready_o | output | 1 | Unit can accept an input vector |
| mask_i | input | LANES | Per-lane enable |
| a_i | input | LANES*16 | First half-precision operand vector |
| b_i | input | LANES*16 | Second half-precision operand vector |
| valid_o | output | 1 | Output vector present |
| ready_i | input | 1 | Consumer takes the output vector |
| data_o | output | LANES*8 | Int8 result vector |

## Verification
A table of operand pairs is replicated across all lanes. It holds exact integers, half-way fractions, values just above and just below a half, and sums above 127. Between them these pairs separate round-to-nearest-even from truncation and from round-half-up, and separate saturation from wrap-around. Further entries use opposite-signed operands, negative zero, infinities and NaN; these show that the clamp comes before the conversion and that the special-value mapping is right. One pair adds the smallest subnormal to one half, which exposes any design that rounds to half precision before converting. Random vectors mixing all exponent classes are streamed back to back and checked against a real-valued model. Partial masks, stalls held for several cycles and a single isolated vector then check lane gating, data holding and the exact cycle count.

// File: rtl/addrelu_pkg.sv
package addrelu_pkg;
  localparam int FP_W    = 16;
  localparam int EXP_W   = 5;
  localparam int MAN_W   = 10;
  localparam int OUT_W   = 8;
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  // fixed-point LSB weight is the smallest subnormal: 2^-(BIAS-1+MAN_W)
  localparam int FRAC_W  = BIAS - 1 + MAN_W;
  localparam int MAG_W   = MAN_W + 1 + (1 << EXP_W) - 3;
  localparam int SUM_W   = MAG_W + 2;
  localparam int INT_W   = SUM_W - FRAC_W;
  localparam int OUT_MAX = (1 << (OUT_W - 1)) - 1;
  localparam int PIPE_STAGES = 3;

  typedef struct packed {
    logic             neg;
    logic             inf;
    logic             nan;
    logic [MAG_W-1:0] mag;
  } fix_opnd_t;

  typedef enum logic [1:0] {
    CLS_FIN  = 2'd0,
    CLS_ZERO = 2'd1,
    CLS_SAT  = 2'd2
  } sum_cls_e;
endpackage

// File: rtl/addrelu_pipe_ctrl.sv
module addrelu_pipe_ctrl #(
  parameter int DEPTH = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic ready_i,
  output logic ready_o,
  output logic en_o,
  output logic valid_o
);
  logic [DEPTH-1:0] vld_q;

  assign en_o    = ~vld_q[DEPTH-1] | ready_i;
  assign ready_o = en_o;
  assign valid_o = vld_q[DEPTH-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
    end else if (en_o) begin
      vld_q <= {vld_q[DEPTH-2:0], valid_i};
    end
  end
endmodule

// File: rtl/addrelu_fp16_to_fix.sv
module addrelu_fp16_to_fix
  import addrelu_pkg::*;
(
  input  logic [FP_W-1:0] bits_i,
  output fix_opnd_t       opnd_o
);
  logic [EXP_W-1:0] exp_w;
  logic [MAN_W-1:0] man_w;
  logic [MAN_W:0]   sig_w;
  logic [EXP_W-1:0] sh_w;
  logic             exp_max;

  always_comb begin
    exp_w   = bits_i[FP_W-2 -: EXP_W];
    man_w   = bits_i[MAN_W-1:0];
    exp_max = &exp_w;
    sig_w   = {|exp_w, man_w};
    // subnormals share the shift of the smallest normal exponent
    sh_w    = (exp_w == '0) ? '0 : exp_w - EXP_W'(1);
    opnd_o.neg = bits_i[FP_W-1];
    opnd_o.inf = exp_max && (man_w == '0);
    opnd_o.nan = exp_max && (man_w != '0);
    opnd_o.mag = exp_max ? '0 : (MAG_W'(sig_w) << sh_w);
  end
endmodule

// File: rtl/addrelu_rnd_sat.sv
module addrelu_rnd_sat
  import addrelu_pkg::*;
(
  input  logic signed [SUM_W-1:0] sum_i,
  input  sum_cls_e                cls_i,
  input  logic                    act_i,
  output logic [OUT_W-1:0]        q_o
);
  logic [INT_W-1:0] int_w;
  logic [INT_W:0]   rnd_w;
  logic             guard_w, sticky_w, up_w, nonpos_w;

  always_comb begin
    int_w    = sum_i[SUM_W-1:FRAC_W];
    guard_w  = sum_i[FRAC_W-1];
    sticky_w = |sum_i[FRAC_W-2:0];
    up_w     = guard_w & (sticky_w | int_w[0]);
    rnd_w    = {1'b0, int_w} + (INT_W+1)'(up_w);
    nonpos_w = sum_i[SUM_W-1] || (sum_i == '0);
    if (!act_i || cls_i == CLS_ZERO) begin
      q_o = '0;
    end else if (cls_i == CLS_SAT) begin
      q_o = OUT_W'(OUT_MAX);
    end else if (nonpos_w) begin
      q_o = '0;
    end else if (rnd_w > (INT_W+1)'(OUT_MAX)) begin
      q_o = OUT_W'(OUT_MAX);
    end else begin
      q_o = rnd_w[OUT_W-1:0];
    end
  end
endmodule

// File: rtl/addrelu_lane.sv
module addrelu_lane
  import addrelu_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             act_i,
  input  logic [FP_W-1:0]  a_i,
  input  logic [FP_W-1:0]  b_i,
  output logic [OUT_W-1:0] q_o
);
  fix_opnd_t opa_d, opb_d, opa_q, opb_q;
  logic      act1_q, act2_q;

  logic signed [SUM_W-1:0] ext_a, ext_b, sum_d, sum_q;
  sum_cls_e                cls_d, cls_q;
  logic                    nan_any;
  logic [OUT_W-1:0]        q_d, q_q;

  addrelu_fp16_to_fix u_unpack_a (.bits_i(a_i), .opnd_o(opa_d));
  addrelu_fp16_to_fix u_unpack_b (.bits_i(b_i), .opnd_o(opb_d));

  always_comb begin
    ext_a = opa_q.neg ? -$signed({2'b00, opa_q.mag}) : $signed({2'b00, opa_q.mag});
    ext_b = opb_q.neg ? -$signed({2'b00, opb_q.mag}) : $signed({2'b00, opb_q.mag});
    sum_d = ext_a + ext_b;
    nan_any = opa_q.nan | opb_q.nan |
              (opa_q.inf & opb_q.inf & (opa_q.neg ^ opb_q.neg));
    if (nan_any) begin
      cls_d = CLS_ZERO;
    end else if ((opa_q.inf & ~opa_q.neg) | (opb_q.inf & ~opb_q.neg)) begin
      cls_d = CLS_SAT;
    end else if (opa_q.inf | opb_q.inf) begin
      cls_d = CLS_ZERO;
    end else begin
      cls_d = CLS_FIN;
    end
  end

  addrelu_rnd_sat u_rnd_sat (
    .sum_i (sum_q),
    .cls_i (cls_q),
    .act_i (act2_q),
    .q_o   (q_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opa_q  <= '0;
      opb_q  <= '0;
      act1_q <= 1'b0;
      sum_q  <= '0;
      cls_q  <= CLS_ZERO;
      act2_q <= 1'b0;
      q_q    <= '0;
    end else if (en_i) begin
      opa_q  <= opa_d;
      opb_q  <= opb_d;
      act1_q <= act_i;
      sum_q  <= sum_d;
      cls_q  <= cls_d;
      act2_q <= act1_q;
      q_q    <= q_d;
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/addrelu_conv_vec.sv
module addrelu_conv_vec
  import addrelu_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  output logic                   ready_o,
  input  logic [LANES-1:0]       mask_i,
  input  logic [LANES*FP_W-1:0]  a_i,
  input  logic [LANES*FP_W-1:0]  b_i,
  output logic                   valid_o,
  input  logic                   ready_i,
  output logic [LANES*OUT_W-1:0] data_o
);
  logic pipe_en;

  addrelu_pipe_ctrl #(.DEPTH(PIPE_STAGES)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .ready_i (ready_i),
    .ready_o (ready_o),
    .en_o    (pipe_en),
    .valid_o (valid_o)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    addrelu_lane u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (pipe_en),
      .act_i  (mask_i[g]),
      .a_i    (a_i[g*FP_W +: FP_W]),
      .b_i    (b_i[g*FP_W +: FP_W]),
      .q_o    (data_o[g*OUT_W +: OUT_W])
    );
  end
endmodule

// File: rtl/addrelu_conv_vec_chk.sv
module addrelu_conv_vec_chk
  import addrelu_pkg::*;
#(
  parameter int LANES = 16
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   valid_i,
  input logic                   ready_o,
  input logic                   valid_o,
  input logic                   ready_i,
  input logic [LANES*OUT_W-1:0] data_o
);
  logic [LANES-1:0] top_bits;
  for (genvar g = 0; g < LANES; g++) begin : g_top
    assign top_bits[g] = data_o[g*OUT_W + OUT_W - 1];
  end

  AST_OUT_NONNEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (top_bits == '0)); // R4

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o))); // R9

  AST_STALL_NO_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |-> !ready_o); // R9

  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) ##1 ready_o ##1 ready_o |=> valid_o); // R8
endmodule

bind addrelu_conv_vec addrelu_conv_vec_chk #(.LANES(LANES)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .ready_o (ready_o),
  .valid_o (valid_o),
  .ready_i (ready_i),
  .data_o  (data_o)
);

// File: tb/addrelu_conv_vec_bench.sv
module addrelu_conv_vec_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 8;
  localparam int AW = LANES * 16;
  localparam int DW = LANES * 8;
  localparam int NRAND = 48;
  localparam int NTBL = 21;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic ready_i = 1'b1;
  logic ready_o, valid_o;
  logic [LANES-1:0] mask_i = '0;
  logic [AW-1:0] a_i = '0;
  logic [AW-1:0] b_i = '0;
  logic [DW-1:0] data_o;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addrelu_conv_vec #(.LANES(LANES)) u_addrelu_conv_vec (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .ready_o (ready_o),
    .mask_i  (mask_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .valid_o (valid_o),
    .ready_i (ready_i),
    .data_o  (data_o)
  );

  // {a, b, expected}
  localparam logic [39:0] TBL [NTBL] = '{
    {16'h5640, 16'h4900, 8'd110},  // R1 100+10
    {16'h5800, 16'hBC00, 8'd127},  // R1 128-1
    {16'h3C00, 16'h3C00, 8'd2},    // R1
    {16'h3BFF, 16'h0000, 8'd1},    // R1 just below 1
    {16'h3C01, 16'h0000, 8'd1},    // R1 just above 1
    {16'h3800, 16'h0001, 8'd1},    // R2 single rounding
    {16'h3800, 16'h0000, 8'd0},    // R3
    {16'h3E00, 16'h0000, 8'd2},    // R3
    {16'h4100, 16'h0000, 8'd2},    // R3
    {16'h4300, 16'h0000, 8'd4},    // R3
    {16'h57F0, 16'h3800, 8'd127},  // R4 127.5
    {16'h7BFF, 16'h7BFF, 8'd127},  // R4 max finite
    {16'h57F0, 16'h0000, 8'd127},  // R4 exact 127
    {16'hC000, 16'h3C00, 8'd0},    // R5 negative
    {16'h8000, 16'h8000, 8'd0},    // R5 -0
    {16'h3C00, 16'hBC00, 8'd0},    // R5 exact zero
    {16'h7C00, 16'hC000, 8'd127},  // R6 +inf
    {16'hFC00, 16'h7BFF, 8'd0},    // R6 -inf
    {16'h7C00, 16'hFC00, 8'd0},    // R6 inf-inf
    {16'h7E00, 16'h3C00, 8'd0},    // R6 NaN
    {16'h3C00, 16'hFD01, 8'd0}     // R6 negative NaN
  };

  function automatic real h2r(input logic [15:0] h);
    int  e = int'(h[14:10]);
    int  m = int'(h[9:0]);
    real mag;
    if (e == 0) mag = real'(m) * (2.0 ** (-24));
    else        mag = real'(1024 + m) * (2.0 ** (e - 25));
    return h[15] ? -mag : mag;
  endfunction

  function automatic logic [7:0] ref_q(input logic [15:0] a, input logic [15:0] b);
    bit  a_sp = (a[14:10] == 5'h1F);
    bit  b_sp = (b[14:10] == 5'h1F);
    bit  a_nan = a_sp && (a[9:0] != 0);
    bit  b_nan = b_sp && (b[9:0] != 0);
    bit  a_inf = a_sp && (a[9:0] == 0);
    bit  b_inf = b_sp && (b[9:0] == 0);
    real s, fl, fr;
    int  iv;
    if (a_nan || b_nan) return 8'd0;
    if (a_inf && b_inf && (a[15] != b[15])) return 8'd0;
    if ((a_inf && !a[15]) || (b_inf && !b[15])) return 8'd127;
    if (a_inf || b_inf) return 8'd0;
    s = h2r(a) + h2r(b);
    if (s <= 0.0) return 8'd0;
    if (s >= 128.0) return 8'd127;
    fl = $floor(s);
    fr = s - fl;
    iv = $rtoi(fl);
    if (fr > 0.5 || (fr == 0.5 && (iv % 2) == 1)) iv++;
    if (iv > 127) iv = 127;
    return 8'(iv);
  endfunction

  function automatic logic [DW-1:0] ref_vec(input logic [AW-1:0] a, input logic [AW-1:0] b,
                                            input logic [LANES-1:0] m);
    logic [DW-1:0] r = '0;
    for (int i = 0; i < LANES; i++)
      if (m[i]) r[i*8 +: 8] = ref_q(a[i*16 +: 16], b[i*16 +: 16]);
    return r;
  endfunction

  function automatic logic [15:0] rnd_half();
    int sel = int'($urandom_range(0, 9));
    logic [4:0] e;
    if (sel == 0) return 16'($urandom);
    if (sel == 1) e = 5'h1F;
    else if (sel == 2) e = 5'h00;
    else e = 5'($urandom_range(10, 22));
    return {1'($urandom), e, 10'($urandom)};
  endfunction

  function automatic logic [AW-1:0] rnd_vec();
    logic [AW-1:0] v;
    for (int i = 0; i < LANES; i++) v[i*16 +: 16] = rnd_half();
    return v;
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run_one(input logic [AW-1:0] a, input logic [AW-1:0] b,
                         input logic [LANES-1:0] m, output logic [DW-1:0] d, output logic v);
    @(negedge clk);
    a_i = a; b_i = b; mask_i = m; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    repeat (2) @(negedge clk);
    d = data_o;
    v = valid_o;
  endtask

  logic [AW-1:0] ra [NRAND];
  logic [AW-1:0] rb [NRAND];
  logic [DW-1:0] rexp [NRAND];

  initial begin
    logic [DW-1:0] d, expv;
    logic v;
    logic [AW-1:0] va, vb, wa, wb;

    // R10 reset state
    repeat (3) @(negedge clk);
    chk("R10 valid_o in reset", DW'(valid_o), '0);
    chk("R10 data_o in reset", data_o, '0);
    chk("R10 ready_o in reset", DW'(ready_o), DW'(1));
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 valid_o after reset", DW'(valid_o), '0);

    // table walk, every lane same pair
    for (int t = 0; t < NTBL; t++) begin
      va = '0; vb = '0; expv = '0;
      for (int i = 0; i < LANES; i++) begin
        va[i*16 +: 16] = TBL[t][39:24];
        vb[i*16 +: 16] = TBL[t][23:8];
        expv[i*8 +: 8] = TBL[t][7:0];
      end
      run_one(va, vb, '1, d, v);
      chk($sformatf("R1-table entry %0d valid (R8)", t), DW'(v), DW'(1));
      chk($sformatf("R1/R2/R3/R4/R5/R6 table entry %0d", t), d, expv);
    end

    // R7 partial and empty masks
    va = rnd_vec(); vb = rnd_vec();
    run_one(va, vb, LANES'(8'hA5), d, v);
    chk("R7 mask 0xA5", d, ref_vec(va, vb, LANES'(8'hA5)));
    va = '0; vb = '0;
    for (int i = 0; i < LANES; i++) begin
      va[i*16 +: 16] = 16'h7C00;
      vb[i*16 +: 16] = 16'h5640;
    end
    run_one(va, vb, '0, d, v);
    chk("R7 mask zero with saturating operands", d, '0);
    run_one(va, vb, LANES'(1), d, v);
    chk("R7 only lane 0", d, DW'(8'd127));

    // R8 exact latency
    @(negedge clk);
    a_i = rnd_vec(); b_i = rnd_vec(); mask_i = '1; valid_i = 1'b1;
    expv = ref_vec(a_i, b_i, mask_i);
    @(negedge clk);
    valid_i = 1'b0;
    chk("R8 no output after 1 edge", DW'(valid_o), '0);
    @(negedge clk);
    chk("R8 no output after 2 edges", DW'(valid_o), '0);
    @(negedge clk);
    chk("R8 output after 3 edges", DW'(valid_o), DW'(1));
    chk("R8 data after 3 edges", data_o, expv);
    @(negedge clk);
    chk("R8 single pulse", DW'(valid_o), '0);

    // R9 backpressure with two vectors in flight
    va = rnd_vec(); vb = rnd_vec(); wa = rnd_vec(); wb = rnd_vec();
    ready_i = 1'b0;
    a_i = va; b_i = vb; mask_i = '1; valid_i = 1'b1;
    @(negedge clk);
    a_i = wa; b_i = wb;
    @(negedge clk);
    valid_i = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      chk("R9 valid held", DW'(valid_o), DW'(1));
      chk("R9 ready_o low", DW'(ready_o), '0);
      chk("R9 data held", data_o, ref_vec(va, vb, '1));
      @(negedge clk);
    end
    ready_i = 1'b1;
    @(negedge clk);
    chk("R9 second vector after release", data_o, ref_vec(wa, wb, '1));
    chk("R9 second valid", DW'(valid_o), DW'(1));
    @(negedge clk);
    chk("R9 drained", DW'(valid_o), '0);

    // R11 / R1 random stream
    for (int k = 0; k < NRAND; k++) begin
      ra[k] = rnd_vec(); rb[k] = rnd_vec();
      rexp[k] = ref_vec(ra[k], rb[k], '1);
    end
    fork
      begin
        for (int k = 0; k < NRAND; k++) begin
          @(negedge clk);
          a_i = ra[k]; b_i = rb[k]; mask_i = '1; valid_i = 1'b1;
        end
        @(negedge clk);
        valid_i = 1'b0;
      end
      begin
        int got = 0;
        int t_now = 0;
        int t_first = 0;
        while (got < NRAND) begin
          @(negedge clk);
          t_now++;
          if (valid_o) begin
            if (got == 0) t_first = t_now;
            chk($sformatf("R1 R11 random vector %0d", got), data_o, rexp[got]);
            got++;
          end
        end
        chk("R11 consecutive cycles", DW'(t_now - t_first), DW'(NRAND - 1));
      end
    join

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R11 watchdog act=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule